// File: doc/BRIEF.md
# Quad-Channel Serial DAC Command Interface

This block is the digital front end of a four-channel digital-to-analog converter. Up to four identical devices share one SPI-style bus. Each device receives 24-bit command frames on a serial data line, qualified by an active-low frame sync and a serial clock. The block runs on its own system clock. It brings the three serial lines into that clock domain, detects falling edges of the serial clock, and assembles a frame. The top eight bits of a frame are control and the low sixteen are payload.

Each channel has a staging register and an active register. Every entry holds either a 16-bit code or a power-down request with a 2-bit mode. A two-pin hardware strap gives the device its bus address. The four load commands are:

- store to staging only;
- store and apply one channel;
- apply one channel while every other channel reloads from its staging register;
- a bus-wide broadcast that every device obeys whatever its address. The broadcast either reloads all active registers from staging, or writes the incoming word into every channel.

The receiver is a three-state machine:

| State | Meaning |
|---|---|
| `RX_IDLE` | sync is high |
| `RX_SHIFT` | bits are being collected |
| `RX_HOLD` | a full frame has been taken and further clocks are ignored |

| Transition | Condition |
|---|---|
| `RX_IDLE` to `RX_SHIFT` | sync is seen low |
| `RX_SHIFT` to `RX_HOLD` | the 24th bit arrives |
| `RX_SHIFT` to `RX_IDLE` | sync rises early (abort) |
| `RX_HOLD` to `RX_IDLE` | sync rises |

Top module: `qdac_serial_if`

## Requirements
- R1: After reset every staging and active register holds a data entry of code 0. Every channel then shows code 0, power-down flag 0 and mode 00.
- R2: Bits are taken MSB first on falling edges of `sclk` while `sync_n` is low. The command executes once the 24th bit is taken. Any further `sclk` edges before `sync_n` rises are ignored.
- R3: If `sync_n` rises before 24 bits have been taken, the partial frame is dropped and no register changes.
- R4: Frame bits 23:22 must equal `addr_pin[1:0]`. A non-broadcast frame whose address differs changes nothing.
- R5: Frame bits 18:17 pick the channel: 00 for A, 01 for B, 10 for C and 11 for D. Channel A is output slice 0. Bit 19 has no effect.
- R6: Load bits 21:20 = 00 write the incoming entry to the selected staging register only, and no active output changes.
- R7: Load bits = 01 write the incoming entry to both the staging and the active register of the selected channel.
- R8: Load bits = 10 write the incoming entry to the selected channel's staging and active registers. In the same cycle, each other channel's active register takes its own staged entry. A mix of codes and power-down entries may be applied this way.
- R9: Load bits = 11 with bit 18 = 0 is accepted at any address. All four active registers take their staged entries and the payload is discarded.
- R10: Load bits = 11 with bit 18 = 1 is accepted at any address. The incoming entry is written to all four staging and all four active registers.
- R11: Bit 16 = 1 makes the entry a power-down request with mode bits 15:14. Its channel then shows `pd_en_o`=1, that mode on `pd_mode_o`, and code 0. A data entry shows `pd_en_o`=0, mode 00 and its 16-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_pin | input | 2 | Hardware address strap |
| sync_n | input | 1 | Active-low frame sync |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| act_code_o | output | 64 | Active codes, channel A in bits 15:0 |
| pd_mode_o | output | 8 | Power-down mode per channel, 2 bits each |
| pd_en_o | output | 4 | Power-down active flag per channel |

## Verification
A wrong active register shows at the outputs within about five system clocks of the 24th serial edge. The bench compares every output on every clock, so such an error is caught almost at once. A corrupt staging register stays hidden until a simultaneous or reload broadcast copies it out. For this reason the test sequence follows each store with one of those commands. A receiver that miscounts bits, or keeps a partial frame, shows up as a channel change where none is expected after an aborted or mismatched frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int FRAME_W = 24;
    localparam int DATA_W  = 16;
    localparam int NUM_CH  = 4;
    localparam int ADDR_W  = 2;
    localparam int MODE_W  = 2;

    typedef struct packed {
        logic              pd;
        logic [DATA_W-1:0] word;
    } chan_ent_t;

    typedef enum logic [1:0] {
        LD_STORE  = 2'b00,
        LD_UPDATE = 2'b01,
        LD_SIMUL  = 2'b10,
        LD_BCAST  = 2'b11
    } load_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_SHIFT = 2'b01,
        RX_HOLD  = 2'b10
    } rx_state_e;
endpackage

// File: rtl/qdac_spi_rx.sv
module qdac_spi_rx
    import qdac_pkg::*;
#(
    parameter int FRAME_BITS  = FRAME_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_n,
    input  logic                  sclk,
    input  logic                  sdin,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic [SYNC_STAGES-1:0] sclk_pipe, sync_pipe, sdin_pipe;
    logic sclk_d, sync_d;
    logic sclk_s, sync_s, sdin_s, sclk_fall;

    rx_state_e state, nxt;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] sr;

    // input synchronisers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_pipe <= '1;
            sync_pipe <= '1;
            sdin_pipe <= '0;
            sclk_d    <= 1'b1;
            sync_d    <= 1'b1;
        end else begin
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
            sync_pipe <= {sync_pipe[SYNC_STAGES-2:0], sync_n};
            sdin_pipe <= {sdin_pipe[SYNC_STAGES-2:0], sdin};
            sclk_d    <= sclk_pipe[SYNC_STAGES-1];
            sync_d    <= sync_pipe[SYNC_STAGES-1];
        end
    end

    assign sclk_s    = sclk_pipe[SYNC_STAGES-1];
    assign sync_s    = sync_pipe[SYNC_STAGES-1];
    assign sdin_s    = sdin_pipe[SYNC_STAGES-1];
    assign sclk_fall = sclk_d & ~sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (!sync_s) nxt = RX_SHIFT;
            RX_SHIFT: begin
                if (sync_s)                          nxt = RX_IDLE;
                else if (sclk_fall && cnt == LAST_BIT) nxt = RX_HOLD;
            end
            RX_HOLD:  if (sync_s) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            sr        <= '0;
            frame     <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            if (state == RX_SHIFT && !sync_s) begin
                if (sclk_fall) begin
                    sr  <= {sr[FRAME_BITS-2:0], sdin_s};
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        frame     <= {sr[FRAME_BITS-2:0], sdin_s};
                        frame_vld <= 1'b1;
                    end
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld); // R2
    AST_RX_HOLD_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> state == RX_HOLD); // R2
    AST_RX_ABORT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SHIFT && sync_s) |=> !frame_vld); // R3
    AST_RX_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |=> !frame_vld); // R3
endmodule

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
    import qdac_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_W,
    parameter int DBITS      = DATA_W,
    parameter int CHANNELS   = NUM_CH,
    parameter int ABITS      = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_vld,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic [ABITS-1:0]      addr_pin,
    output logic [CHANNELS-1:0]   stg_we,
    output logic [CHANNELS-1:0]   act_new,
    output logic [CHANNELS-1:0]   act_from_stg,
    output chan_ent_t             new_ent
);
    localparam int ADDR_LSB = FRAME_BITS - ABITS;
    localparam int LD_LSB   = DBITS + 4;
    localparam int SEL_LSB  = DBITS + 1;
    localparam int PD_BIT   = DBITS;
    localparam int SEL_W    = $clog2(CHANNELS);

    logic [ABITS-1:0] hdr_addr;
    logic             match;
    load_e            ld;
    logic [SEL_W-1:0] sel;
    logic [CHANNELS-1:0] sel_oh;
    logic             bc_write;

    assign hdr_addr = frame[ADDR_LSB +: ABITS];
    assign match    = (hdr_addr == addr_pin);
    assign ld       = load_e'(frame[LD_LSB +: 2]);
    assign sel      = frame[SEL_LSB +: SEL_W];
    assign sel_oh   = CHANNELS'(1) << sel;
    assign bc_write = frame[SEL_LSB + SEL_W - 1];
    assign new_ent  = '{pd: frame[PD_BIT], word: frame[DBITS-1:0]};

    always_comb begin
        stg_we       = '0;
        act_new      = '0;
        act_from_stg = '0;
        if (frame_vld) begin
            unique case (ld)
                LD_STORE: if (match) stg_we = sel_oh;
                LD_UPDATE: if (match) begin
                    stg_we  = sel_oh;
                    act_new = sel_oh;
                end
                LD_SIMUL: if (match) begin
                    stg_we       = sel_oh;
                    act_new      = sel_oh;
                    act_from_stg = ~sel_oh;
                end
                LD_BCAST: begin
                    if (bc_write) begin
                        stg_we  = '1;
                        act_new = '1;
                    end else begin
                        act_from_stg = '1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DEC_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !match && ld != LD_BCAST)
        |-> (stg_we == '0 && act_new == '0 && act_from_stg == '0)); // R4
    AST_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (act_new & act_from_stg) == '0); // R8
    AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |-> (stg_we == '0 && act_new == '0 && act_from_stg == '0)); // R2
    AST_DEC_STORE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && ld == LD_STORE) |-> ($countones(stg_we) <= 1 && act_new == '0)); // R6
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
    import qdac_pkg::*;
#(
    parameter int CHANNELS = NUM_CH,
    parameter int DBITS    = DATA_W,
    parameter int MBITS    = MODE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CHANNELS-1:0]       stg_we,
    input  logic [CHANNELS-1:0]       act_new,
    input  logic [CHANNELS-1:0]       act_from_stg,
    input  chan_ent_t                 new_ent,
    output logic [CHANNELS*DBITS-1:0] act_code_o,
    output logic [CHANNELS*MBITS-1:0] pd_mode_o,
    output logic [CHANNELS-1:0]       pd_en_o
);
    chan_ent_t stg [CHANNELS];
    chan_ent_t act [CHANNELS];

    for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[g] <= '0;
                act[g] <= '0;
            end else begin
                if (stg_we[g])            stg[g] <= new_ent;
                if (act_new[g])           act[g] <= new_ent;
                else if (act_from_stg[g]) act[g] <= stg[g];
            end
        end

        assign act_code_o[g*DBITS +: DBITS] = act[g].pd ? '0 : act[g].word;
        assign pd_mode_o[g*MBITS +: MBITS]  = act[g].pd ? act[g].word[DBITS-1 -: MBITS] : '0;
        assign pd_en_o[g]                   = act[g].pd;

        AST_BANK_STG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !stg_we[g] |=> stg[g] == $past(stg[g])); // R6
        AST_BANK_NEW: assert property (@(posedge clk) disable iff (!rst_n)
            act_new[g] |=> act[g] == $past(new_ent)); // R7
        AST_BANK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            act_from_stg[g] |=> act[g] == $past(stg[g])); // R9
        AST_BANK_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!act_new[g] && !act_from_stg[g]) |=> $stable(act[g])); // R3
    end
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
    import qdac_pkg::*;
#(
    parameter int CHANNELS = NUM_CH,
    parameter int DBITS    = DATA_W,
    parameter int MBITS    = MODE_W,
    parameter int ABITS    = ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ABITS-1:0]          addr_pin,
    input  logic                      sync_n,
    input  logic                      sclk,
    input  logic                      sdin,
    output logic [CHANNELS*DBITS-1:0] act_code_o,
    output logic [CHANNELS*MBITS-1:0] pd_mode_o,
    output logic [CHANNELS-1:0]       pd_en_o
);
    localparam int FBITS = DBITS + 8;

    logic              frame_vld;
    logic [FBITS-1:0]  frame;
    logic [CHANNELS-1:0] stg_we, act_new, act_from_stg;
    chan_ent_t         new_ent;

    qdac_spi_rx #(.FRAME_BITS(FBITS), .SYNC_STAGES(2)) u_rx (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .frame_vld(frame_vld), .frame(frame)
    );

    qdac_cmd_decode #(.FRAME_BITS(FBITS), .DBITS(DBITS), .CHANNELS(CHANNELS), .ABITS(ABITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame(frame),
        .addr_pin(addr_pin), .stg_we(stg_we), .act_new(act_new),
        .act_from_stg(act_from_stg), .new_ent(new_ent)
    );

    qdac_chan_bank #(.CHANNELS(CHANNELS), .DBITS(DBITS), .MBITS(MBITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .act_new(act_new),
        .act_from_stg(act_from_stg), .new_ent(new_ent),
        .act_code_o(act_code_o), .pd_mode_o(pd_mode_o), .pd_en_o(pd_en_o)
    );
endmodule

// File: tb/test_qdac_serial_if.sv
module test_qdac_serial_if;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int SETTLE     = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr_pin = 2'b10;
    logic sync_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic [63:0] act_code_o;
    logic [7:0]  pd_mode_o;
    logic [3:0]  pd_en_o;

    logic [16:0] m_stg [4];
    logic [16:0] m_act [4];
    int cyc = 0;
    int pause_until = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_serial_if i_qdac_serial_if (
        .clk(clk), .rst_n(rst_n), .addr_pin(addr_pin), .sync_n(sync_n),
        .sclk(sclk), .sdin(sdin), .act_code_o(act_code_o),
        .pd_mode_o(pd_mode_o), .pd_en_o(pd_en_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // reference model comparison on every settled clock, plus watchdog
    always @(negedge clk) begin
        logic [63:0] ec;
        logic [7:0]  em;
        logic [3:0]  ee;
        if (chk_en && rst_n && cyc >= pause_until) begin
            for (int c = 0; c < 4; c++) begin
                ec[c*16 +: 16] = m_act[c][16] ? 16'h0 : m_act[c][15:0];
                em[c*2 +: 2]   = m_act[c][16] ? m_act[c][15:14] : 2'b00;
                ee[c]          = m_act[c][16];
            end
            n_checks++;
            if (act_code_o !== ec || pd_mode_o !== em || pd_en_o !== ee) begin
                n_fail++;
                $display("FAIL %s: got code=%h mode=%h pd=%h expected code=%h mode=%h pd=%h",
                         cur_req, act_code_o, pd_mode_o, pd_en_o, ec, em, ee);
            end
        end
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: got cycle=%0d expected below %0d", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    function automatic logic [23:0] mk(input logic [1:0] a, input logic [1:0] ld,
                                       input logic x, input logic [1:0] sel,
                                       input logic pd, input logic [15:0] d);
        return {a, ld, x, sel, pd, d};
    endfunction

    function automatic void model_apply(input logic [23:0] f);
        logic [16:0] e;
        logic match;
        int s;
        e = f[16:0];
        match = (f[23:22] == addr_pin);
        s = int'(f[18:17]);
        unique case (f[21:20])
            2'b00: if (match) m_stg[s] = e;
            2'b01: if (match) begin m_stg[s] = e; m_act[s] = e; end
            2'b10: if (match) begin
                for (int c = 0; c < 4; c++) if (c != s) m_act[c] = m_stg[c];
                m_stg[s] = e; m_act[s] = e;
            end
            default: begin
                if (f[18]) for (int c = 0; c < 4; c++) begin m_stg[c] = e; m_act[c] = e; end
                else       for (int c = 0; c < 4; c++) m_act[c] = m_stg[c];
            end
        endcase
    endfunction

    task automatic send(input logic [23:0] f, input int nbits);
        sync_n = 1'b0;
        repeat (HALF) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 24) ? f[23-i] : 1'b1;
            repeat (HALF) @(posedge clk);
            if (i == 23) begin
                pause_until = cyc + SETTLE;
                model_apply(f);
            end
            sclk = 1'b0;
            repeat (HALF) @(posedge clk);
            sclk = 1'b1;
        end
        repeat (HALF) @(posedge clk);
        sync_n = 1'b1;
        repeat (SETTLE + 4) @(posedge clk);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin m_stg[c] = '0; m_act[c] = '0; end
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;
        cur_req = "R1";
        repeat (10) @(posedge clk);

        cur_req = "R6";   // stage channel B only, outputs unchanged
        send(mk(2'b10, 2'b00, 1'b0, 2'b01, 1'b0, 16'h1234), 24);
        cur_req = "R7";   // store and apply channel A
        send(mk(2'b10, 2'b01, 1'b0, 2'b00, 1'b0, 16'hBEEF), 24);
        cur_req = "R5";   // bit 19 set, channel D
        send(mk(2'b10, 2'b01, 1'b1, 2'b11, 1'b0, 16'h0F0F), 24);
        cur_req = "R11";  // stage power-down mode 10 on channel C
        send(mk(2'b10, 2'b00, 1'b0, 2'b10, 1'b1, 16'h8000), 24);
        cur_req = "R8";   // simultaneous: A new, B/C/D from staging
        send(mk(2'b10, 2'b10, 1'b0, 2'b00, 1'b0, 16'h1111), 24);
        cur_req = "R4";   // wrong address, ignored
        send(mk(2'b01, 2'b01, 1'b0, 2'b00, 1'b0, 16'hDEAD), 24);
        send(mk(2'b11, 2'b10, 1'b0, 2'b01, 1'b0, 16'hCAFE), 24);
        cur_req = "R6";
        send(mk(2'b10, 2'b00, 1'b0, 2'b11, 1'b0, 16'h7777), 24);
        send(mk(2'b10, 2'b00, 1'b0, 2'b10, 1'b0, 16'h2222), 24);
        cur_req = "R9";   // reload broadcast from foreign address
        send(mk(2'b01, 2'b11, 1'b0, 2'b01, 1'b0, 16'h5555), 24);
        cur_req = "R10";  // write-all broadcast from foreign address
        send(mk(2'b00, 2'b11, 1'b0, 2'b10, 1'b0, 16'hA5A5), 24);
        send(mk(2'b11, 2'b11, 1'b0, 2'b11, 1'b1, 16'h4000), 24);
        cur_req = "R11";  // data back on A, power-down mode 11 on B
        send(mk(2'b10, 2'b01, 1'b0, 2'b00, 1'b0, 16'h9ABC), 24);
        send(mk(2'b10, 2'b01, 1'b0, 2'b01, 1'b1, 16'hC000), 24);
        cur_req = "R3";   // aborted frames
        send(mk(2'b10, 2'b01, 1'b0, 2'b00, 1'b0, 16'hFFFF), 15);
        send(mk(2'b10, 2'b11, 1'b0, 2'b10, 1'b0, 16'h0001), 23);
        send(mk(2'b10, 2'b01, 1'b0, 2'b10, 1'b0, 16'h3C3C), 24);
        cur_req = "R2";   // extra clocks beyond 24 bits ignored
        send(mk(2'b10, 2'b01, 1'b0, 2'b11, 1'b0, 16'h0123), 28);
        cur_req = "R8";   // mixed reload: stage D then simultaneous on B
        send(mk(2'b10, 2'b00, 1'b0, 2'b11, 1'b1, 16'h4000), 24);
        send(mk(2'b10, 2'b10, 1'b0, 2'b01, 1'b0, 16'h8001), 24);

        repeat (20) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule